// File: doc/BRIEF.md
# IQ Lane Mapper with Rate Conversion

This block connects four channels of I/Q sample streams to a four-lane 64B/66B converter-link core, in both directions. On the transmit side, one 32-bit sample per channel arrives on each cycle of the fast sample clock. The block pairs consecutive samples into one 64-bit word per lane and delivers those words on a core clock that runs at half the sample rate. On the receive side it splits each 64-bit lane word back into two samples and emits them on consecutive sample clocks.

Each direction crosses between the two clocks through its own dual-clock FIFO. The FIFO has eight entries and uses Gray-coded pointers. Two configuration bits set the layout of every 32-bit sample: which component sits in the upper half, and whether the two bytes of each 16-bit component are swapped. Both bits are captured only while the sample-domain reset is held, so the layout cannot change in the middle of a stream. Overflow and underflow in either direction are reported on sticky flags.

Top module: `iq_lane_mapper`

## Requirements
- R1: After reset, `tx_word_valid` is 0, `tx_lane_data` is 0, `rx_smp_valid` is 0, `rx_smp_i`/`rx_smp_q` are 0, and all four error flags are 0.
- R2: Channel c takes its transmit sample from `tx_smp_i[16c+15:16c]` and `tx_smp_q[16c+15:16c]`. Two consecutive accepted samples form the lane word at `tx_lane_data[64c+63:64c]`. The earlier sample goes in bits [31:0] of that word and the later sample in bits [63:32].
- R3: With `cfg_q_high`=0, a 32-bit sample holds I in [31:16] and Q in [15:0]. With `cfg_q_high`=1, Q is in [31:16] and I is in [15:0].
- R4: With `cfg_byte_rev`=1, the two bytes of each 16-bit component are exchanged inside the word. With `cfg_byte_rev`=0, they are left in place.
- R5: `tx_word_valid` stays 0 and `tx_lane_data` stays 0 until the core side has seen at least two words in its FIFO. After that, every buffered word is delivered, in order, one per core cycle.
- R6: A receive lane word is taken only in a core cycle where `rx_lane_valid` is 1. Data presented while it is 0 never appears on the outputs.
- R7: Receive output starts only after two words are buffered. Each word is emitted as its earlier sample and then its later sample, on two consecutive sample clocks with `rx_smp_valid`=1. Whenever `rx_smp_valid` is 0, the sample outputs are 0.
- R8: The configuration inputs are captured only while `smp_rst` is 1. Changing them after reset has no effect on either direction.
- R9: A write to a full FIFO is dropped and sets the sticky flag for that direction (`tx_ovf` or `rx_ovf`). The flag holds until that domain is reset. Words already buffered are delivered intact.
- R10: If the reading side has started and finds its FIFO empty when it needs a word, it sets the sticky flag `tx_unf` or `rx_unf` and drives its output invalid.
- R11: A transmit sample is accepted only when `tx_smp_valid` is 1. Pairing of samples continues across cycles where it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_clk | input | 1 | Sample clock |
| smp_rst | input | 1 | Synchronous active-high reset, sample domain; configuration captured while high |
| core_clk | input | 1 | Core clock, half the sample rate |
| core_rst | input | 1 | Synchronous active-high reset, core domain |
| cfg_q_high | input | 1 | 1: Q in upper half of each sample |
| cfg_byte_rev | input | 1 | 1: swap bytes of each 16-bit component |
| tx_smp_valid | input | 1 | Transmit samples present this cycle |
| tx_smp_i | input | NCH*16 | Transmit I, channel c at [16c+15:16c] |
| tx_smp_q | input | NCH*16 | Transmit Q, channel c at [16c+15:16c] |
| tx_lane_data | output | NCH*64 | Packed words toward the link core, lane c at [64c+63:64c] |
| tx_word_valid | output | 1 | `tx_lane_data` carries a word |
| rx_lane_data | input | NCH*64 | Lane words from the link core |
| rx_lane_valid | input | 1 | `rx_lane_data` is valid |
| rx_smp_i | output | NCH*16 | Received I per channel |
| rx_smp_q | output | NCH*16 | Received Q per channel |
| rx_smp_valid | output | 1 | Received samples valid |
| tx_ovf | output | 1 | Sticky: transmit FIFO overflow (sample domain) |
| tx_unf | output | 1 | Sticky: transmit FIFO underflow (core domain) |
| rx_ovf | output | 1 | Sticky: receive FIFO overflow (core domain) |
| rx_unf | output | 1 | Sticky: receive FIFO underflow (sample domain) |

## Verification
The assertions check the following on every cycle:
- outputs are zero whenever their valid is low;
- the four error flags stay set once raised;
- the captured configuration stays frozen outside reset;
- received samples always come in earlier/later pairs.

The scoreboard scenarios are the only place that shows the bit placement under all four layout settings, pairing across transmit gaps, and that receive words with the valid bit low are ignored. They also show the hold-off before priming, and that exactly the first eight words survive an overflow.

// File: rtl/iqmap_pkg.sv
package iqmap_pkg;

    localparam int COMP_W   = 16;
    localparam int SAMPLE_W = 2 * COMP_W;
    localparam int LANE_W   = 2 * SAMPLE_W;

    typedef struct packed {
        logic q_high;
        logic byte_rev;
    } fmt_cfg_t;

    function automatic logic [COMP_W-1:0] swap_bytes(input logic [COMP_W-1:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    function automatic logic [COMP_W-1:0] opt_swap(input logic [COMP_W-1:0] v, input logic en);
        return en ? swap_bytes(v) : v;
    endfunction

    // Build one 32-bit sample from its components under the selected layout.
    function automatic logic [SAMPLE_W-1:0] fmt_sample(input logic [COMP_W-1:0] i_c,
                                                       input logic [COMP_W-1:0] q_c,
                                                       input fmt_cfg_t cfg);
        logic [COMP_W-1:0] i_s, q_s;
        i_s = opt_swap(i_c, cfg.byte_rev);
        q_s = opt_swap(q_c, cfg.byte_rev);
        return cfg.q_high ? {q_s, i_s} : {i_s, q_s};
    endfunction

    function automatic logic [COMP_W-1:0] get_i(input logic [SAMPLE_W-1:0] s, input fmt_cfg_t cfg);
        return opt_swap(cfg.q_high ? s[COMP_W-1:0] : s[SAMPLE_W-1:COMP_W], cfg.byte_rev);
    endfunction

    function automatic logic [COMP_W-1:0] get_q(input logic [SAMPLE_W-1:0] s, input fmt_cfg_t cfg);
        return opt_swap(cfg.q_high ? s[SAMPLE_W-1:COMP_W] : s[COMP_W-1:0], cfg.byte_rev);
    endfunction

endpackage

// File: rtl/iqmap_async_fifo.sv
// Dual-clock FIFO, Gray-coded pointers, two-flop synchronisers.
// DEPTH must be a power of two.
module iqmap_async_fifo #(
    parameter int W     = 256,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          wr_en,
    input  logic [W-1:0]  wdata,
    output logic          wfull,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          rd_en,
    output logic [W-1:0]  rdata,
    output logic          rempty,
    output logic [CW-1:0] rcount
);

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] wbin, wgray, rbin, rgray;
    logic [CW-1:0] rg_s1, rg_s2, wg_s1, wg_s2;
    logic [CW-1:0] wcount;
    logic          wpush, rpop;

    function automatic logic [CW-1:0] to_gray(input logic [CW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [CW-1:0] from_gray(input logic [CW-1:0] g);
        logic [CW-1:0] b;
        b[CW-1] = g[CW-1];
        for (int k = CW - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
        return b;
    endfunction

    // write side
    assign wcount = wbin - from_gray(rg_s2);
    assign wfull  = (wcount == CW'(DEPTH));
    assign wpush  = wr_en & ~wfull;

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
            rg_s1 <= '0;
            rg_s2 <= '0;
        end else begin
            rg_s1 <= rgray;
            rg_s2 <= rg_s1;
            if (wpush) begin
                wbin  <= wbin + 1'b1;
                wgray <= to_gray(wbin + 1'b1);
            end
        end
    end

    always_ff @(posedge wclk) begin
        if (!wrst && wpush) mem[wbin[AW-1:0]] <= wdata;
    end

    // read side
    assign rcount = from_gray(wg_s2) - rbin;
    assign rempty = (rcount == '0);
    assign rpop   = rd_en & ~rempty;
    assign rdata  = mem[rbin[AW-1:0]];

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin  <= '0;
            rgray <= '0;
            wg_s1 <= '0;
            wg_s2 <= '0;
        end else begin
            wg_s1 <= wgray;
            wg_s2 <= wg_s1;
            if (rpop) begin
                rbin  <= rbin + 1'b1;
                rgray <= to_gray(rbin + 1'b1);
            end
        end
    end

endmodule

// File: rtl/iqmap_tx_pack.sv
// Sample-domain 2:1 gearbox: pairs consecutive accepted samples per lane.
module iqmap_tx_pack
    import iqmap_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  fmt_cfg_t              cfg,
    input  logic                  smp_valid,
    input  logic [NCH*COMP_W-1:0] smp_i,
    input  logic [NCH*COMP_W-1:0] smp_q,
    input  logic                  fifo_full,
    output logic                  fifo_wr,
    output logic [NCH*LANE_W-1:0] fifo_wdata,
    output logic                  ovf
);

    logic                    phase;
    logic [NCH*SAMPLE_W-1:0] held;
    logic [NCH*SAMPLE_W-1:0] fmt_now;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign fmt_now[c*SAMPLE_W +: SAMPLE_W] =
            fmt_sample(smp_i[c*COMP_W +: COMP_W], smp_q[c*COMP_W +: COMP_W], cfg);
        // earlier sample low, later sample high
        assign fifo_wdata[c*LANE_W +: LANE_W] =
            {fmt_now[c*SAMPLE_W +: SAMPLE_W], held[c*SAMPLE_W +: SAMPLE_W]};
    end

    assign fifo_wr = smp_valid & phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b0;
            held  <= '0;
            ovf   <= 1'b0;
        end else if (smp_valid) begin
            phase <= ~phase;
            if (!phase) held <= fmt_now;
            if (phase && fifo_full) ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/iqmap_tx_drain.sv
// Core-domain reader: waits for PRIME words, then one word per cycle.
module iqmap_tx_drain #(
    parameter int W     = 256,
    parameter int CW    = 4,
    parameter int PRIME = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] fifo_count,
    input  logic          fifo_empty,
    input  logic [W-1:0]  fifo_rdata,
    output logic          fifo_rd,
    output logic [W-1:0]  word_out,
    output logic          word_valid,
    output logic          unf
);

    localparam logic [CW-1:0] PRIME_C = CW'(PRIME);

    logic primed, go;

    assign go      = primed | (fifo_count >= PRIME_C);
    assign fifo_rd = go & ~fifo_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            primed     <= 1'b0;
            word_out   <= '0;
            word_valid <= 1'b0;
            unf        <= 1'b0;
        end else begin
            if (fifo_count >= PRIME_C) primed <= 1'b1;
            if (fifo_rd) begin
                word_out   <= fifo_rdata;
                word_valid <= 1'b1;
            end else begin
                word_out   <= '0;
                word_valid <= 1'b0;
                if (go) unf <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/iqmap_rx_unpack.sv
// Sample-domain reader: splits each lane word into two samples.
module iqmap_rx_unpack
    import iqmap_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CW    = 4,
    parameter int PRIME = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  fmt_cfg_t              cfg,
    input  logic [CW-1:0]         fifo_count,
    input  logic                  fifo_empty,
    input  logic [NCH*LANE_W-1:0] fifo_rdata,
    output logic                  fifo_rd,
    output logic [NCH*COMP_W-1:0] out_i,
    output logic [NCH*COMP_W-1:0] out_q,
    output logic                  out_valid,
    output logic                  unf
);

    localparam logic [CW-1:0] PRIME_C = CW'(PRIME);

    logic                    started, phase, go;
    logic [NCH*SAMPLE_W-1:0] upper_q, upper_now;
    logic [NCH*COMP_W-1:0]   lo_i, lo_q, hi_i, hi_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign upper_now[c*SAMPLE_W +: SAMPLE_W] = fifo_rdata[c*LANE_W+SAMPLE_W +: SAMPLE_W];
        assign lo_i[c*COMP_W +: COMP_W] = get_i(fifo_rdata[c*LANE_W +: SAMPLE_W], cfg);
        assign lo_q[c*COMP_W +: COMP_W] = get_q(fifo_rdata[c*LANE_W +: SAMPLE_W], cfg);
        assign hi_i[c*COMP_W +: COMP_W] = get_i(upper_q[c*SAMPLE_W +: SAMPLE_W], cfg);
        assign hi_q[c*COMP_W +: COMP_W] = get_q(upper_q[c*SAMPLE_W +: SAMPLE_W], cfg);
    end

    assign go      = started | (fifo_count >= PRIME_C);
    assign fifo_rd = go & ~phase & ~fifo_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            started   <= 1'b0;
            phase     <= 1'b0;
            upper_q   <= '0;
            out_i     <= '0;
            out_q     <= '0;
            out_valid <= 1'b0;
            unf       <= 1'b0;
        end else begin
            if (fifo_count >= PRIME_C) started <= 1'b1;
            if (phase) begin
                out_i     <= hi_i;
                out_q     <= hi_q;
                out_valid <= 1'b1;
                phase     <= 1'b0;
            end else if (fifo_rd) begin
                upper_q   <= upper_now;
                out_i     <= lo_i;
                out_q     <= lo_q;
                out_valid <= 1'b1;
                phase     <= 1'b1;
            end else begin
                out_i     <= '0;
                out_q     <= '0;
                out_valid <= 1'b0;
                if (go) unf <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/iq_lane_mapper.sv
module iq_lane_mapper
    import iqmap_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int FIFO_DEPTH = 8,
    parameter int PRIME      = 2
) (
    input  logic                  smp_clk,
    input  logic                  smp_rst,
    input  logic                  core_clk,
    input  logic                  core_rst,
    input  logic                  cfg_q_high,
    input  logic                  cfg_byte_rev,
    input  logic                  tx_smp_valid,
    input  logic [NCH*COMP_W-1:0] tx_smp_i,
    input  logic [NCH*COMP_W-1:0] tx_smp_q,
    output logic [NCH*LANE_W-1:0] tx_lane_data,
    output logic                  tx_word_valid,
    input  logic [NCH*LANE_W-1:0] rx_lane_data,
    input  logic                  rx_lane_valid,
    output logic [NCH*COMP_W-1:0] rx_smp_i,
    output logic [NCH*COMP_W-1:0] rx_smp_q,
    output logic                  rx_smp_valid,
    output logic                  tx_ovf,
    output logic                  tx_unf,
    output logic                  rx_ovf,
    output logic                  rx_unf
);

    localparam int WORD_W = NCH * LANE_W;
    localparam int CW     = $clog2(FIFO_DEPTH) + 1;

    fmt_cfg_t          cfg_r;
    logic              txf_wr, txf_full, txf_rd, txf_empty;
    logic [WORD_W-1:0] txf_wdata, txf_rdata;
    logic [CW-1:0]     txf_count;
    logic              rxf_full, rxf_rd, rxf_empty;
    logic [WORD_W-1:0] rxf_rdata;
    logic [CW-1:0]     rxf_count;

    // layout captured only while the sample domain is in reset
    always_ff @(posedge smp_clk) begin
        if (smp_rst) cfg_r <= '{q_high: cfg_q_high, byte_rev: cfg_byte_rev};
    end

    // transmit direction
    iqmap_tx_pack #(.NCH(NCH)) u_tx_pack (
        .clk(smp_clk), .rst(smp_rst), .cfg(cfg_r),
        .smp_valid(tx_smp_valid), .smp_i(tx_smp_i), .smp_q(tx_smp_q),
        .fifo_full(txf_full), .fifo_wr(txf_wr), .fifo_wdata(txf_wdata), .ovf(tx_ovf)
    );

    iqmap_async_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .wclk(smp_clk), .wrst(smp_rst), .wr_en(txf_wr), .wdata(txf_wdata), .wfull(txf_full),
        .rclk(core_clk), .rrst(core_rst), .rd_en(txf_rd), .rdata(txf_rdata),
        .rempty(txf_empty), .rcount(txf_count)
    );

    iqmap_tx_drain #(.W(WORD_W), .CW(CW), .PRIME(PRIME)) u_tx_drain (
        .clk(core_clk), .rst(core_rst),
        .fifo_count(txf_count), .fifo_empty(txf_empty), .fifo_rdata(txf_rdata),
        .fifo_rd(txf_rd), .word_out(tx_lane_data), .word_valid(tx_word_valid), .unf(tx_unf)
    );

    // receive direction
    always_ff @(posedge core_clk) begin
        if (core_rst)                       rx_ovf <= 1'b0;
        else if (rx_lane_valid && rxf_full) rx_ovf <= 1'b1;
    end

    iqmap_async_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .wclk(core_clk), .wrst(core_rst), .wr_en(rx_lane_valid), .wdata(rx_lane_data),
        .wfull(rxf_full),
        .rclk(smp_clk), .rrst(smp_rst), .rd_en(rxf_rd), .rdata(rxf_rdata),
        .rempty(rxf_empty), .rcount(rxf_count)
    );

    iqmap_rx_unpack #(.NCH(NCH), .CW(CW), .PRIME(PRIME)) u_rx_unpack (
        .clk(smp_clk), .rst(smp_rst), .cfg(cfg_r),
        .fifo_count(rxf_count), .fifo_empty(rxf_empty), .fifo_rdata(rxf_rdata),
        .fifo_rd(rxf_rd), .out_i(rx_smp_i), .out_q(rx_smp_q),
        .out_valid(rx_smp_valid), .unf(rx_unf)
    );

endmodule

// File: rtl/iq_lane_mapper_chk.sv
module iq_lane_mapper_chk
    import iqmap_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic                  smp_clk,
    input logic                  smp_rst,
    input logic                  core_clk,
    input logic                  core_rst,
    input fmt_cfg_t              cfg_r,
    input logic [NCH*LANE_W-1:0] tx_lane_data,
    input logic                  tx_word_valid,
    input logic [NCH*COMP_W-1:0] rx_smp_i,
    input logic [NCH*COMP_W-1:0] rx_smp_q,
    input logic                  rx_smp_valid,
    input logic                  tx_ovf,
    input logic                  tx_unf,
    input logic                  rx_ovf,
    input logic                  rx_unf
);

    a_r5_tx_zero_when_idle: assert property (@(posedge core_clk) disable iff (core_rst)
        !tx_word_valid |-> (tx_lane_data == '0));

    a_r7_rx_zero_when_idle: assert property (@(posedge smp_clk) disable iff (smp_rst)
        !rx_smp_valid |-> (rx_smp_i == '0 && rx_smp_q == '0));

    a_r7_rx_pairs: assert property (@(posedge smp_clk) disable iff (smp_rst)
        $rose(rx_smp_valid) |=> rx_smp_valid);

    a_r8_cfg_frozen: assert property (@(posedge smp_clk) disable iff (smp_rst)
        !smp_rst |=> $stable(cfg_r));

    a_r9_tx_ovf_sticky: assert property (@(posedge smp_clk) disable iff (smp_rst)
        tx_ovf |=> tx_ovf);

    a_r9_rx_ovf_sticky: assert property (@(posedge core_clk) disable iff (core_rst)
        rx_ovf |=> rx_ovf);

    a_r10_tx_unf_sticky: assert property (@(posedge core_clk) disable iff (core_rst)
        tx_unf |=> tx_unf);

    a_r10_rx_unf_sticky: assert property (@(posedge smp_clk) disable iff (smp_rst)
        rx_unf |=> rx_unf);

endmodule

bind iq_lane_mapper iq_lane_mapper_chk #(.NCH(NCH)) u_chk (
    .smp_clk(smp_clk), .smp_rst(smp_rst), .core_clk(core_clk), .core_rst(core_rst),
    .cfg_r(cfg_r), .tx_lane_data(tx_lane_data), .tx_word_valid(tx_word_valid),
    .rx_smp_i(rx_smp_i), .rx_smp_q(rx_smp_q), .rx_smp_valid(rx_smp_valid),
    .tx_ovf(tx_ovf), .tx_unf(tx_unf), .rx_ovf(rx_ovf), .rx_unf(rx_unf)
);

// File: tb/iq_lane_mapper_tb_top.sv
module iq_lane_mapper_tb_top;

    localparam int NCH = 4;

    logic smp_clk = 1'b0, core_clk = 1'b0;
    logic smp_rst = 1'b1, core_rst = 1'b1;
    logic cfg_q_high = 1'b0, cfg_byte_rev = 1'b0;
    logic tx_smp_valid = 1'b0;
    logic [NCH*16-1:0] tx_smp_i = '0, tx_smp_q = '0;
    logic [NCH*64-1:0] tx_lane_data;
    logic tx_word_valid;
    logic [NCH*64-1:0] rx_lane_data = '0;
    logic rx_lane_valid = 1'b0;
    logic [NCH*16-1:0] rx_smp_i, rx_smp_q;
    logic rx_smp_valid, tx_ovf, tx_unf, rx_ovf, rx_unf;

    iq_lane_mapper #(.NCH(NCH)) dut_i (.*);

    // 50 MHz sample clock; core clock at half rate, rising with every other sample edge
    always #10 smp_clk = ~smp_clk;
    initial begin
        #10;
        forever begin core_clk = 1'b1; #20; core_clk = 1'b0; #20; end
    end

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    bit exp_qh, exp_br;
    string tx_req = "R2", rx_req = "R6";
    logic [NCH*64-1:0] tx_exp[$];
    logic [NCH*32-1:0] rx_exp[$];
    bit tx_half;
    logic [NCH*32-1:0] tx_early;
    int tx_words, tx_limit, rx_limit;

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bfmt(input logic [15:0] i, input logic [15:0] q, input bit qh, input bit br);
        logic [15:0] a, b;
        a = br ? {i[7:0], i[15:8]} : i;
        b = br ? {q[7:0], q[15:8]} : q;
        return qh ? {b, a} : {a, b};
    endfunction

    function automatic logic [15:0] pat(input int k, input int c, input int sel);
        return 16'((k * 1103 + c * 7919 + sel * 40503 + 16'h2A5C) & 16'hFFFF);
    endfunction

    // scoreboard monitors
    always @(negedge core_clk) begin
        if (!core_rst && tx_word_valid) begin
            if (tx_exp.size() == 0) chk(1'b0, {tx_req, " unexpected tx word"}, tx_lane_data, '0);
            else begin
                logic [NCH*64-1:0] e;
                e = tx_exp.pop_front();
                chk(tx_lane_data === e, {tx_req, " tx lane word"}, tx_lane_data, e);
            end
        end
    end

    always @(negedge smp_clk) begin
        if (!smp_rst && rx_smp_valid) begin
            if (rx_exp.size() == 0) chk(1'b0, {rx_req, " unexpected rx sample"}, {rx_smp_i, rx_smp_q}, '0);
            else begin
                logic [NCH*32-1:0] e;
                e = rx_exp.pop_front();
                chk({rx_smp_i, rx_smp_q} === e, {rx_req, " rx sample"}, {rx_smp_i, rx_smp_q}, e);
            end
        end
    end

    task automatic do_reset(input bit qh, input bit br, input bit hold_core, input bit hold_smp);
        @(negedge smp_clk);
        smp_rst = 1; core_rst = 1; cfg_q_high = qh; cfg_byte_rev = br;
        tx_smp_valid = 0; rx_lane_valid = 0;
        repeat (6) @(negedge smp_clk);
        exp_qh = qh; exp_br = br; tx_half = 0; tx_words = 0;
        tx_limit = 1 << 30; rx_limit = 1 << 30;
        tx_exp.delete(); rx_exp.delete();
        if (!hold_smp) smp_rst = 0;
        if (!hold_core) begin @(negedge core_clk); core_rst = 0; end
        @(negedge smp_clk);
    endtask

    task automatic tx_stream(input int n, input int base, input bit gaps);
        logic [NCH*64-1:0] w;
        w = '0;
        for (int s = 0; s < n; s++) begin
            @(negedge smp_clk);
            tx_smp_valid = 1;
            for (int c = 0; c < NCH; c++) begin
                logic [31:0] f;
                tx_smp_i[c*16 +: 16] = pat(base + s, c, 0);
                tx_smp_q[c*16 +: 16] = pat(base + s, c, 1);
                f = bfmt(tx_smp_i[c*16 +: 16], tx_smp_q[c*16 +: 16], exp_qh, exp_br);
                if (!tx_half) tx_early[c*32 +: 32] = f;
                else w[c*64 +: 64] = {f, tx_early[c*32 +: 32]};
            end
            if (tx_half) begin
                if (tx_words < tx_limit) tx_exp.push_back(w);
                tx_words++;
            end
            tx_half = ~tx_half;
            if (gaps && (s % 3 == 1)) begin
                @(negedge smp_clk);
                tx_smp_valid = 0; tx_smp_i = ~tx_smp_i; tx_smp_q = ~tx_smp_q;
            end
        end
        @(negedge smp_clk) tx_smp_valid = 0;
    endtask

    task automatic rx_stream(input int nw, input int base, input bit gaps);
        for (int w = 0; w < nw; w++) begin
            logic [NCH*16-1:0] ei, eq, li, lq;
            @(negedge core_clk);
            rx_lane_valid = 1;
            for (int c = 0; c < NCH; c++) begin
                ei[c*16 +: 16] = pat(base + 2*w, c, 2);
                eq[c*16 +: 16] = pat(base + 2*w, c, 3);
                li[c*16 +: 16] = pat(base + 2*w + 1, c, 2);
                lq[c*16 +: 16] = pat(base + 2*w + 1, c, 3);
                rx_lane_data[c*64 +: 64] = {bfmt(li[c*16 +: 16], lq[c*16 +: 16], exp_qh, exp_br),
                                            bfmt(ei[c*16 +: 16], eq[c*16 +: 16], exp_qh, exp_br)};
            end
            if (w < rx_limit) begin
                rx_exp.push_back({ei, eq});
                rx_exp.push_back({li, lq});
            end
            if (gaps && (w % 2 == 0)) begin
                @(negedge core_clk);
                rx_lane_valid = 0; rx_lane_data = ~rx_lane_data;
            end
        end
        @(negedge core_clk) rx_lane_valid = 0;
    endtask

    task automatic drain_and_close(input string tag);
        repeat (40) @(negedge core_clk);
        @(negedge smp_clk);
        chk(tx_exp.size() == 0, {tag, " R5 every tx word delivered"}, tx_exp.size(), 0);
        chk(rx_exp.size() == 0, {tag, " R7 every rx sample delivered"}, rx_exp.size(), 0);
        chk(tx_unf && rx_unf, {tag, " R10 underflow flags after stream end"}, {tx_unf, rx_unf}, 2'b11);
    endtask

    task automatic plain_run(input bit qh, input bit br, input string tr, input string rr, input bit gaps);
        do_reset(qh, br, 0, 0);
        tx_req = tr; rx_req = rr;
        fork
            tx_stream(24, 100 * (qh + 2 * br), gaps);
            rx_stream(8, 300 + 50 * (qh + 2 * br), gaps);
        join
        drain_and_close(tr);
        chk(!tx_ovf && !rx_ovf, {tr, " R9 no overflow at line rate"}, {tx_ovf, rx_ovf}, 2'b00);
    endtask

    initial begin
        // T1: reset state, priming hold-off, default layout
        do_reset(0, 0, 0, 0);
        chk(tx_word_valid == 0 && tx_lane_data == '0, "R1 tx outputs after reset", {tx_word_valid, tx_lane_data}, 0);
        chk(rx_smp_valid == 0 && rx_smp_i == '0 && rx_smp_q == '0, "R1 rx outputs after reset",
            {rx_smp_valid, rx_smp_i, rx_smp_q}, 0);
        chk({tx_ovf, tx_unf, rx_ovf, rx_unf} == 4'b0, "R1 error flags after reset", {tx_ovf, tx_unf, rx_ovf, rx_unf}, 0);
        tx_req = "R2"; rx_req = "R7";
        fork
            tx_stream(2, 0, 0);
            rx_stream(1, 500, 0);
        join
        repeat (20) @(negedge core_clk);
        chk(tx_word_valid == 0 && tx_lane_data == '0 && tx_exp.size() == 1,
            "R5 one word buffered gives no output", {tx_word_valid, tx_exp.size()}, 1);
        @(negedge smp_clk);
        chk(rx_smp_valid == 0 && rx_smp_i == '0 && rx_exp.size() == 2,
            "R7 one rx word buffered gives no output", {rx_smp_valid, rx_exp.size()}, 2);
        fork
            tx_stream(30, 2, 0);
            rx_stream(7, 502, 0);
        join
        drain_and_close("R2");

        // T2..T4: layouts, with gaps in T2
        plain_run(1, 0, "R3 R11", "R3 R6", 1);
        plain_run(0, 1, "R4", "R4", 0);
        plain_run(1, 1, "R3 R4", "R3 R4", 0);

        // T5: configuration change after reset is ignored
        do_reset(0, 0, 0, 0);
        cfg_q_high = 1; cfg_byte_rev = 1;
        tx_req = "R8"; rx_req = "R8";
        fork
            tx_stream(16, 700, 0);
            rx_stream(6, 800, 0);
        join
        drain_and_close("R8");
        cfg_q_high = 0; cfg_byte_rev = 0;

        // T6: transmit overflow with core side held in reset
        do_reset(0, 1, 1, 0);
        tx_req = "R9"; tx_limit = 8;
        tx_stream(20, 900, 0);
        @(negedge smp_clk);
        chk(tx_ovf == 1, "R9 tx overflow flagged", tx_ovf, 1);
        chk(tx_word_valid == 0, "R9 no tx output while core held", tx_word_valid, 0);
        @(negedge core_clk) core_rst = 0;
        repeat (40) @(negedge core_clk);
        @(negedge smp_clk);
        chk(tx_exp.size() == 0 && tx_ovf == 1, "R9 first eight tx words kept, flag sticky",
            {tx_exp.size(), tx_ovf}, 1);

        // T7: receive overflow with sample side held in reset
        do_reset(1, 0, 0, 1);
        rx_req = "R9"; rx_limit = 8;
        rx_stream(10, 1000, 0);
        @(negedge core_clk);
        chk(rx_ovf == 1, "R9 rx overflow flagged", rx_ovf, 1);
        @(negedge smp_clk) smp_rst = 0;
        repeat (60) @(negedge smp_clk);
        chk(rx_exp.size() == 0 && rx_ovf == 1, "R9 first eight rx words kept, flag sticky",
            {rx_exp.size(), rx_ovf}, 1);
        chk(rx_unf == 1, "R10 rx underflow after drain", rx_unf, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge smp_clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule